// File: doc/BRIEF.md
# Input Capture Unit with Noise Filter

This block timestamps transitions on an asynchronous input pin. The pin first passes through a synchronizer. It can then pass through an optional digital filter, which passes a new level only after the synchronized pin has held that level for four consecutive clock cycles. An edge detector then watches for the polarity that software selects. When that edge arrives and capturing is enabled, the value of a free-running counter from outside the block is copied into a capture register, and a sticky capture flag is raised.

The flag stays set until a clear strobe arrives. An interrupt request is the flag gated by an interrupt enable. The counter and all register access belong to the surrounding timer.

The filter and the unfiltered path are tracked side by side. Because of this, switching the filter on or off, or flipping the edge polarity, cannot by itself produce a capture.

Top module: `edge_stamp_capture`

## Requirements
- R1: After reset, `cap_value` is 0, `cap_flag` is 0 and `cap_irq` is 0.
- R2: With `edge_sel`=1 and `flt_en`=0, a rising transition of `cap_pin` is first sampled at clock edge k. The unit copies the `counter` value present at edge k+2 into `cap_value`, and `cap_flag` is 1 after that edge.
- R3: With `edge_sel`=0, a falling transition is captured with the same timing. A transition in the unselected direction leaves `cap_value` and `cap_flag` unchanged.
- R4: While `cap_en`=0, no transition alters `cap_value` or sets `cap_flag`. A transition that occurred while disabled is not captured after `cap_en` returns to 1.
- R5: With `flt_en`=1, the level seen by the edge detector changes only after four consecutive equal synchronized samples. A pin pulse shorter than four cycles is never captured; a pulse of four or more cycles is captured.
- R6: With `flt_en`=1, a transition first sampled at edge k is captured at edge k+6, exactly four cycles later than without the filter.
- R7: `cap_flag` stays at 1 until `flag_clr` is sampled high, which clears it. If a capture and `flag_clr` coincide on the same edge, the flag stays at 1 and the new value is stored.
- R8: `cap_irq` is 1 exactly when `cap_flag` and `irq_en` are both 1.
- R9: Toggling `edge_sel` or `flt_en` while `cap_pin` is steady never sets `cap_flag`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_pin | input | 1 | Asynchronous capture pin |
| counter | input | CNT_W | Free-running counter value to be stamped |
| cap_en | input | 1 | Capture enable |
| flt_en | input | 1 | Filter enable (1 = four-sample filter in path) |
| edge_sel | input | 1 | Edge polarity: 0 falling, 1 rising |
| flag_clr | input | 1 | One-cycle strobe that clears the capture flag |
| irq_en | input | 1 | Interrupt enable |
| cap_value | output | CNT_W | Last captured counter value |
| cap_flag | output | 1 | Sticky capture flag |
| cap_irq | output | 1 | Interrupt request |

## Verification
The properties assume that the pin is treated as a level that may move on any cycle. They also assume that `counter` and the control bits are synchronous to `clk`, and that `flag_clr` is a plain level sampled on each edge.

The stimulus changes every input only between clock edges. It holds the pin steady long enough for both the raw and the filtered levels to settle before each measured transition. Polarity and filter switching are exercised only while the pin is quiet, so each observed capture traces back to a single real transition.

// File: rtl/edge_stamp_pkg.sv
package edge_stamp_pkg;

    localparam int unsigned DEF_CNT_W        = 16;
    localparam int unsigned DEF_SYNC_STAGES  = 2;
    localparam int unsigned DEF_FILT_SAMPLES = 4;

    typedef enum logic {
        POL_FALL = 1'b0,
        POL_RISE = 1'b1
    } edge_pol_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_pair_t;

    typedef struct packed {
        logic raw;
        logic clean;
    } level_pair_t;

    function automatic edge_pair_t find_edges(input logic cur, input logic prev);
        edge_pair_t e;
        e.rise = cur & ~prev;
        e.fall = ~cur & prev;
        return e;
    endfunction

    function automatic logic pick_edge(input edge_pair_t e, input edge_pol_e pol);
        logic hit;
        case (pol)
            POL_RISE: hit = e.rise;
            default:  hit = e.fall;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/es_sync.sv
module es_sync #(
    parameter int unsigned STAGES  = edge_stamp_pkg::DEF_SYNC_STAGES,
    parameter logic        RST_LVL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic nxt;
        logic q_r;
        if (i == 0) begin : g_first
            assign nxt = d;
        end else begin : g_rest
            assign nxt = g_stage[i-1].q_r;
        end
        always_ff @(posedge clk) begin
            if (rst) q_r <= RST_LVL;
            else     q_r <= nxt;
        end
    end

    assign q = g_stage[STAGES-1].q_r;

endmodule

// File: rtl/es_filter.sv
module es_filter #(
    parameter int unsigned SAMPLES = edge_stamp_pkg::DEF_FILT_SAMPLES,
    parameter logic        RST_LVL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);

    localparam int unsigned HIST_W = SAMPLES - 1;

    logic [HIST_W-1:0] hist;
    logic              lvl_q;
    logic              agree;

    // The new sample and every stored sample must carry the same level.
    always_comb begin
        agree = 1'b1;
        for (int i = 0; i < HIST_W; i++) begin
            if (hist[i] != d) agree = 1'b0;
        end
    end

    if (HIST_W == 1) begin : g_short
        always_ff @(posedge clk) begin
            if (rst) hist <= RST_LVL;
            else     hist <= d;
        end
    end else begin : g_long
        always_ff @(posedge clk) begin
            if (rst) hist <= {HIST_W{RST_LVL}};
            else     hist <= {hist[HIST_W-2:0], d};
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        lvl_q <= RST_LVL;
        else if (agree) lvl_q <= d;
    end

    assign q = lvl_q;

endmodule

// File: rtl/es_edge.sv
module es_edge
    import edge_stamp_pkg::*;
#(
    parameter logic RST_LVL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    input  logic clean,
    input  logic use_clean,
    input  logic pol,
    output logic hit
);

    level_pair_t cur;
    level_pair_t prev;
    edge_pair_t  e_raw;
    edge_pair_t  e_clean;
    edge_pair_t  e_sel;

    assign cur.raw   = raw;
    assign cur.clean = clean;

    // Both paths keep their own history, so changing the source or the
    // polarity never compares levels that belong to different paths.
    always_ff @(posedge clk) begin
        if (rst) prev <= '{raw: RST_LVL, clean: RST_LVL};
        else     prev <= cur;
    end

    always_comb begin
        e_raw   = find_edges(cur.raw, prev.raw);
        e_clean = find_edges(cur.clean, prev.clean);
        e_sel   = use_clean ? e_clean : e_raw;
        hit     = pick_edge(e_sel, edge_pol_e'(pol));
    end

endmodule

// File: rtl/es_capture.sv
module es_capture #(
    parameter int unsigned CNT_W = edge_stamp_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit,
    input  logic             enable,
    input  logic             clr,
    input  logic [CNT_W-1:0] counter,
    output logic [CNT_W-1:0] value,
    output logic             flag
);

    logic             take;
    logic [CNT_W-1:0] value_q;
    logic             flag_q;

    assign take = hit & enable;

    always_ff @(posedge clk) begin
        if (rst) begin
            value_q <= '0;
            flag_q  <= 1'b0;
        end else begin
            if (take) value_q <= counter;
            if (take)     flag_q <= 1'b1;
            else if (clr) flag_q <= 1'b0;
        end
    end

    assign value = value_q;
    assign flag  = flag_q;

endmodule

// File: rtl/edge_stamp_capture.sv
module edge_stamp_capture
    import edge_stamp_pkg::*;
#(
    parameter int unsigned CNT_W        = DEF_CNT_W,
    parameter int unsigned SYNC_STAGES  = DEF_SYNC_STAGES,
    parameter int unsigned FILT_SAMPLES = DEF_FILT_SAMPLES,
    parameter logic        PIN_RST      = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_pin,
    input  logic [CNT_W-1:0] counter,
    input  logic             cap_en,
    input  logic             flt_en,
    input  logic             edge_sel,
    input  logic             flag_clr,
    input  logic             irq_en,
    output logic [CNT_W-1:0] cap_value,
    output logic             cap_flag,
    output logic             cap_irq
);

    logic sync_lvl;
    logic filt_lvl;
    logic edge_hit;

    es_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_LVL (PIN_RST)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (cap_pin),
        .q   (sync_lvl)
    );

    es_filter #(
        .SAMPLES (FILT_SAMPLES),
        .RST_LVL (PIN_RST)
    ) u_filter (
        .clk (clk),
        .rst (rst),
        .d   (sync_lvl),
        .q   (filt_lvl)
    );

    es_edge #(
        .RST_LVL (PIN_RST)
    ) u_edge (
        .clk       (clk),
        .rst       (rst),
        .raw       (sync_lvl),
        .clean     (filt_lvl),
        .use_clean (flt_en),
        .pol       (edge_sel),
        .hit       (edge_hit)
    );

    es_capture #(
        .CNT_W (CNT_W)
    ) u_capture (
        .clk     (clk),
        .rst     (rst),
        .hit     (edge_hit),
        .enable  (cap_en),
        .clr     (flag_clr),
        .counter (counter),
        .value   (cap_value),
        .flag    (cap_flag)
    );

    assign cap_irq = cap_flag & irq_en;

endmodule

// File: rtl/edge_stamp_checks.sv
module edge_stamp_checks #(
    parameter int unsigned CNT_W        = 16,
    parameter int unsigned FILT_SAMPLES = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             cap_en,
    input logic             flag_clr,
    input logic [CNT_W-1:0] counter,
    input logic [CNT_W-1:0] cap_value,
    input logic             cap_flag,
    input logic             trig,
    input logic             sync_lvl,
    input logic             filt_lvl
);

    localparam int unsigned RUN_W = $clog2(FILT_SAMPLES + 1);

    logic             sync_d;
    logic [RUN_W-1:0] run;

    // Length of the current run of equal synchronized samples, saturating.
    always_ff @(posedge clk) begin
        if (rst) begin
            sync_d <= 1'b0;
            run    <= '0;
        end else begin
            sync_d <= sync_lvl;
            if (sync_lvl != sync_d)             run <= RUN_W'(1);
            else if (run < RUN_W'(FILT_SAMPLES)) run <= run + 1'b1;
        end
    end

    p_take_stores_r2: assert property (@(posedge clk) disable iff (rst)
        (trig && cap_en) |=> (cap_flag && cap_value == $past(counter)));

    p_hold_disabled_r4: assert property (@(posedge clk) disable iff (rst)
        !cap_en |=> $stable(cap_value));

    p_flag_cause_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(cap_flag) |-> ($past(cap_en) && $past(trig)));

    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (cap_flag && !flag_clr) |=> cap_flag);

    p_flag_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !(trig && cap_en)) |=> !cap_flag);

    p_filter_run_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(filt_lvl) |-> (run >= RUN_W'(FILT_SAMPLES)));

endmodule

bind edge_stamp_capture edge_stamp_checks #(
    .CNT_W        (CNT_W),
    .FILT_SAMPLES (FILT_SAMPLES)
) u_checks (
    .clk       (clk),
    .rst       (rst),
    .cap_en    (cap_en),
    .flag_clr  (flag_clr),
    .counter   (counter),
    .cap_value (cap_value),
    .cap_flag  (cap_flag),
    .trig      (edge_hit),
    .sync_lvl  (sync_lvl),
    .filt_lvl  (filt_lvl)
);

// File: tb/sim_edge_stamp_capture.sv
module sim_edge_stamp_capture;

    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          pin;
    logic [CW-1:0] cnt;
    logic          en, fen, sel, clr, ien;
    logic [CW-1:0] cap_value;
    logic          cap_flag, cap_irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    edge_stamp_capture #(.CNT_W(CW)) u0 (
        .clk       (clk),
        .rst       (rst),
        .cap_pin   (pin),
        .counter   (cnt),
        .cap_en    (en),
        .flt_en    (fen),
        .edge_sel  (sel),
        .flag_clr  (clr),
        .irq_en    (ien),
        .cap_value (cap_value),
        .cap_flag  (cap_flag),
        .cap_irq   (cap_irq)
    );

    // Inputs move and outputs are read at the falling edge; the counter
    // advances by one per cycle.
    task automatic tick();
        @(negedge clk);
        cnt = cnt + 1'b1;
    endtask

    task automatic ticks(input int n);
        repeat (n) tick();
    endtask

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_flag();
        clr = 1'b1;
        tick();
        clr = 1'b0;
    endtask

    task automatic wait_flag(input int n, output int seen);
        seen = -1;
        for (int i = 1; i <= n; i++) begin
            tick();
            if (cap_flag && seen < 0) seen = i;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [CW-1:0] c0;
        logic [CW-1:0] old;
        int seen;

        rst = 1'b1; pin = 1'b0; cnt = '0; en = 1'b1; fen = 1'b0;
        sel = 1'b1; clr = 1'b0; ien = 1'b1;
        ticks(3);
        rst = 1'b0;
        #1;
        chk("R1", "value after reset", cap_value, 0);
        chk("R1", "flag after reset", cap_flag, 0);
        chk("R1", "irq after reset", cap_irq, 0);

        // Sweep: filter x polarity x transition direction.
        for (int f = 0; f < 2; f++) begin
            for (int s = 0; s < 2; s++) begin
                for (int d = 0; d < 2; d++) begin
                    fen = f[0]; sel = s[0]; pin = ~d[0];
                    ticks(12);
                    clear_flag();
                    old = cap_value;
                    c0  = cnt;
                    pin = d[0];
                    wait_flag(12, seen);
                    if (d == s) begin
                        chk(s == 1 ? "R2" : "R3", "captured value", cap_value,
                            CW'(c0 + CW'(2 + 4 * f)));
                        chk(f == 1 ? "R6" : "R2", "cycles to flag", seen, 3 + 4 * f);
                    end else begin
                        chk("R3", "unselected edge flag", seen, -1);
                        chk("R3", "unselected edge value", cap_value, old);
                    end
                end
            end
        end

        // Pulse width sweep through the filter, rising edge selected.
        fen = 1'b1; sel = 1'b1; pin = 1'b0;
        ticks(12);
        clear_flag();
        for (int len = 1; len <= 6; len++) begin
            old = cap_value;
            c0  = cnt;
            pin = 1'b1;
            ticks(len);
            pin = 1'b0;
            wait_flag(14, seen);
            if (len >= 4) begin
                chk("R5", "long pulse flag", cap_flag, 1);
                chk("R5", "long pulse value", cap_value, CW'(c0 + CW'(6)));
            end else begin
                chk("R5", "short pulse flag", cap_flag, 0);
                chk("R5", "short pulse value", cap_value, old);
            end
            clear_flag();
        end

        // A one-cycle pulse without the filter is still captured.
        fen = 1'b0;
        ticks(12);
        clear_flag();
        c0  = cnt;
        pin = 1'b1;
        tick();
        pin = 1'b0;
        wait_flag(10, seen);
        chk("R2", "one-cycle pulse value", cap_value, CW'(c0 + CW'(2)));

        // Toggling polarity and filter with a quiet pin, at both levels.
        for (int lvl = 0; lvl < 2; lvl++) begin
            fen = 1'b1; sel = 1'b1; pin = lvl[0];
            ticks(12);
            clear_flag();
            old = cap_value;
            for (int i = 0; i < 6; i++) begin
                sel = ~sel;
                tick();
                fen = ~fen;
                tick();
            end
            ticks(3);
            chk("R9", "flag after control toggling", cap_flag, 0);
            chk("R9", "value after control toggling", cap_value, old);
        end

        // Disabled capture.
        fen = 1'b0; sel = 1'b1; pin = 1'b0;
        ticks(12);
        clear_flag();
        old = cap_value;
        en  = 1'b0;
        pin = 1'b1;
        ticks(10);
        chk("R4", "flag while disabled", cap_flag, 0);
        chk("R4", "value while disabled", cap_value, old);
        en = 1'b1;
        ticks(5);
        chk("R4", "no late capture", cap_flag, 0);

        // Sticky flag, coincident clear, interrupt gating.
        pin = 1'b0;
        ticks(12);
        clear_flag();
        c0  = cnt;
        pin = 1'b1;
        ticks(4);
        chk("R7", "first capture flag", cap_flag, 1);
        pin = 1'b0;
        ticks(4);
        c0  = cnt;
        pin = 1'b1;
        ticks(2);
        clr = 1'b1;
        tick();
        clr = 1'b0;
        chk("R7", "capture wins over clear", cap_flag, 1);
        chk("R7", "value on coincident clear", cap_value, CW'(c0 + CW'(2)));
        ticks(5);
        chk("R7", "flag stays set", cap_flag, 1);
        ien = 1'b0;
        #1;
        chk("R8", "irq masked", cap_irq, 0);
        ien = 1'b1;
        #1;
        chk("R8", "irq raised", cap_irq, 1);
        clear_flag();
        chk("R7", "flag cleared by strobe", cap_flag, 0);
        chk("R8", "irq after clear", cap_irq, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule